// File: doc/BRIEF.md
# Scaled-Counter Four-Channel PWM Unit

This block produces four pulse-width-modulated outputs from one shared free-running counter. The counter is shifted right by a 4-bit scale before it reaches four 16-bit comparators, so the scale picks a power-of-two period. Each channel raises a compare flag while the scaled count is at or above its compare value. Its output pin is the inverse of that flag, so the pin is high for compare/65536 of each period. A compare value of zero leaves the pin low, and no compare value gives a pin that is always high.

Software drives the unit through single-cycle read and write strobes on a 32-bit register bus. The counter can be made to run continuously or for exactly one period. A compare-zero mode lets channel 0's compare value set a shorter period. A sticky mode holds the compare flags until software writes them clear. The counter and its scaled value can both be read back, and a write to the counter loads it. When the scale and a compare value are changed close together, one period may run with the new scale and the old compare value. The block does not guard against this.

Top module: `pwm_scaled4`

## Requirements
- R1: A synchronous reset clears every register, including the latched flags, to zero. After reset the configuration word reads 0xF000_0000, because every compare value of 0 is met. The counter and all compare values read 0, cmp_flag is 4'hF and pwm_n is 4'h0.
- R2: The register offsets are: configuration 0x00, counter 0x08, scaled counter 0x10, and compare i at 0x20+4*i. A compare register stores and returns only bits 15:0. Configuration bits are: scale 3:0, sticky 8, zero-compare 9, run-always 12, run-once 13, and the flags of channels 3..0 in bits 31:28. All other configuration bits read 0. Unmapped offsets read 0, and every read returns 0 while bus_rd is low.
- R3: The counter advances by one per clock while run-always or run-once is set. It holds its value while both are clear.
- R4: A write to offset 0x08 loads the counter with write-data bits 30:0. The write takes priority over counting and over any period reset.
- R5: Offset 0x10 reads the counter shifted right by the scale, truncated to 16 bits.
- R6: With sticky clear, flag i is 1 exactly when scaled count >= compare i, and pwm_n[i] is its inverse. A compare value of 0 keeps pwm_n[i] low.
- R7: With zero-compare clear, a running counter returns to 0 on the clock after it reaches 2^(16+scale)-1, so a period lasts 2^(16+scale) clocks.
- R8: With zero-compare set, a running counter becomes 0 on the clock after the scaled count first reaches compare 0. The period is then (compare0 << scale) + 1 clocks.
- R9: Run-once clears itself on the clock where the counter wraps or is reset by zero-compare. The counter then stops at 0 unless run-always is set.
- R10: With sticky set, a flag that has been set stays set until a configuration write. A configuration write loads the latched flags from bits 31:28, so writing 0 there clears them.
- R11: For compare value 0xFFFF the pin is high for every scaled count except 0xFFFF, so a duty cycle of 100% never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd | input | 1 | Read strobe; bus_rdata is valid in the same cycle |
| bus_wr | input | 1 | Write strobe; the register updates at the next clock edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; 0 when bus_rd is low |
| pwm_n | output | 4 | Inverted pulse outputs, one per channel |
| cmp_flag | output | 4 | Per-channel compare flags |

## Verification
Reads are combinational: a read strobe and its data fall in the same cycle. A register write becomes visible one edge after the strobe. The counter steps once per edge, and a wrap or zero-compare reset shows as 0 one edge after the terminal count. The flags and pins follow the count with no added delay, except the latched sticky part, which captures a flag one edge late. The bench drives inputs and samples results at falling edges. It predicts the counter value edge by edge from the loaded value, the scale and the period rule, and derives every flag and pin from that prediction. Sweeps cover all sixteen scales, the counter wrap at two scales, two zero-compare periods and a single run-once period.

// File: rtl/pwm_scaled4.sv
module pwm_scaled4 #(
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [3:0]        pwm_n,
  output logic [3:0]        cmp_flag
);
  localparam int NCH    = 4;
  localparam int MAXSC  = (1 << SCALE_W) - 1;
  localparam int CNT_W  = CMP_W + MAXSC;
  localparam int A_CFG  = 'h00;
  localparam int A_CNT  = 'h08;
  localparam int A_SCL  = 'h10;
  localparam int A_CMP  = 'h20;
  localparam int B_STK  = 8;
  localparam int B_ZC   = 9;
  localparam int B_ENA  = 12;
  localparam int B_ENO  = 13;
  localparam int B_IP   = 28;

  logic [SCALE_W-1:0] scale_q;
  logic               sticky_q, zc_q, ena_q, eno_q;
  logic [NCH-1:0]     ip_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CMP_W-1:0]   cmp_q [NCH];

  logic [CMP_W-1:0]   scaled;
  logic [CNT_W-1:0]   pmask;
  logic [NCH-1:0]     hit, flag, wr_cmp;
  logic               run, wrap, pend, wr_cfg, wr_cnt;

  assign run    = ena_q | eno_q;
  assign scaled = CMP_W'(cnt_q >> scale_q);
  assign pmask  = {CNT_W{1'b1}} >> (SCALE_W'(MAXSC) - scale_q);
  assign wrap   = (cnt_q & pmask) == pmask;
  assign pend   = run & (wrap | (zc_q & hit[0]));
  assign wr_cfg = bus_wr && (bus_addr == ADDR_W'(A_CFG));
  assign wr_cnt = bus_wr && (bus_addr == ADDR_W'(A_CNT));

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign hit[i]    = scaled >= cmp_q[i];
      assign wr_cmp[i] = bus_wr && (bus_addr == ADDR_W'(A_CMP + 4 * i));
    end
  endgenerate

  assign flag     = hit | ({NCH{sticky_q}} & ip_q);
  assign cmp_flag = flag;
  assign pwm_n    = ~flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      scale_q  <= '0;
      sticky_q <= 1'b0;
      zc_q     <= 1'b0;
      ena_q    <= 1'b0;
      eno_q    <= 1'b0;
      ip_q     <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < NCH; i++) cmp_q[i] <= '0;
    end else begin
      if (wr_cfg) begin
        scale_q  <= bus_wdata[SCALE_W-1:0];
        sticky_q <= bus_wdata[B_STK];
        zc_q     <= bus_wdata[B_ZC];
        ena_q    <= bus_wdata[B_ENA];
        eno_q    <= bus_wdata[B_ENO];
        ip_q     <= bus_wdata[B_IP +: NCH];
      end else begin
        ip_q <= flag;
        if (pend && !wr_cnt) eno_q <= 1'b0;
      end
      if (wr_cnt)   cnt_q <= bus_wdata[CNT_W-1:0];
      else if (run) cnt_q <= pend ? '0 : cnt_q + CNT_W'(1);
      for (int i = 0; i < NCH; i++)
        if (wr_cmp[i]) cmp_q[i] <= bus_wdata[CMP_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_W'(A_CFG)) begin
        bus_rdata[SCALE_W-1:0]  = scale_q;
        bus_rdata[B_STK]        = sticky_q;
        bus_rdata[B_ZC]         = zc_q;
        bus_rdata[B_ENA]        = ena_q;
        bus_rdata[B_ENO]        = eno_q;
        bus_rdata[B_IP +: NCH]  = flag;
      end
      if (bus_addr == ADDR_W'(A_CNT)) bus_rdata = DATA_W'(cnt_q);
      if (bus_addr == ADDR_W'(A_SCL)) bus_rdata = DATA_W'(scaled);
      for (int i = 0; i < NCH; i++)
        if (bus_addr == ADDR_W'(A_CMP + 4 * i)) bus_rdata = DATA_W'(cmp_q[i]);
    end
  end
endmodule

// File: rtl/pwm_scaled4_chk.sv
module pwm_scaled4_chk #(
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4,
  parameter int ADDR_W  = 8
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             bus_wr,
  input logic [ADDR_W-1:0]                bus_addr,
  input logic [CMP_W+(1<<SCALE_W)-2:0]    cnt_q,
  input logic [SCALE_W-1:0]               scale_q,
  input logic                             zc_q,
  input logic                             ena_q,
  input logic                             eno_q,
  input logic                             sticky_q,
  input logic [CMP_W-1:0]                 cmp0,
  input logic [CMP_W-1:0]                 cmp1,
  input logic [CMP_W-1:0]                 cmp2,
  input logic [CMP_W-1:0]                 cmp3,
  input logic [3:0]                       pwm_n,
  input logic [3:0]                       cmp_flag
);
  localparam int CW = CMP_W + (1 << SCALE_W) - 1;

  logic          cfg_wr, cnt_wr, going;
  logic [CW-1:0] top;
  logic [CMP_W-1:0] sc;
  assign cfg_wr = bus_wr && (bus_addr == ADDR_W'(0));
  assign cnt_wr = bus_wr && (bus_addr == ADDR_W'(8));
  assign going  = ena_q || eno_q;
  assign top    = CW'((64'd1 << (CMP_W + int'(scale_q))) - 64'd1);
  assign sc     = CMP_W'(cnt_q >> scale_q);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!going && !cnt_wr) |=> $stable(cnt_q));

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (going && !cnt_wr && !zc_q && ((cnt_q & top) == top)) |=> (cnt_q == '0));

  // R8
  zc_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (going && !cnt_wr && zc_q && (sc >= cmp0)) |=> (cnt_q == '0));

  // R9
  once_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(eno_q) |-> ((cnt_q == '0) || $past(cfg_wr)));

  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmp0 == '0) |-> !pwm_n[0]) and ((cmp1 == '0) |-> !pwm_n[1]) and
    ((cmp2 == '0) |-> !pwm_n[2]) and ((cmp3 == '0) |-> !pwm_n[3]));

  // R10
  sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (sticky_q && !cfg_wr) |=> ((cmp_flag & $past(cmp_flag)) == $past(cmp_flag)));
endmodule

bind pwm_scaled4 pwm_scaled4_chk chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .cnt_q(cnt_q), .scale_q(scale_q), .zc_q(zc_q), .ena_q(ena_q),
  .eno_q(eno_q), .sticky_q(sticky_q),
  .cmp0(cmp_q[0]), .cmp1(cmp_q[1]), .cmp2(cmp_q[2]), .cmp3(cmp_q[3]),
  .pwm_n(pwm_n), .cmp_flag(cmp_flag)
);

// File: tb/pwm_scaled4_tb_top.sv
module pwm_scaled4_tb_top;
  logic        clk = 1'b0, rst = 1'b1, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire  [3:0]  pwm_n, cmp_flag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] cmpv [4];
  logic [31:0] d, c0, c1;

  always #10 clk = ~clk;

  pwm_scaled4 dut_i (.clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_n(pwm_n), .cmp_flag(cmp_flag));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    bus_rd = 1'b0;
    #1;
  endtask

  task automatic set_cmp(input int i, input logic [15:0] v);
    cmpv[i] = v;
    wr(8'(32 + 4 * i), {16'h0, v});
  endtask

  function automatic logic [3:0] exp_flags(input logic [15:0] sc);
    logic [3:0] f;
    for (int i = 0; i < 4; i++) f[i] = sc >= cmpv[i];
    return f;
  endfunction

  task automatic chk_out(input string tag, input logic [15:0] sc);
    chk({tag, " flags"}, {28'h0, cmp_flag}, {28'h0, exp_flags(sc)});
    chk({tag, " pins"}, {28'h0, pwm_n}, {28'h0, ~exp_flags(sc)});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) cmpv[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, d); chk("R1 cfg", d, 32'hF000_0000);
    rd(8'h08, d); chk("R1 counter", d, 0);
    for (int i = 0; i < 4; i++) begin rd(8'(32 + 4 * i), d); chk("R1 compare", d, 0); end
    chk("R1 pins", {28'h0, pwm_n}, 32'h0);
    chk("R1 flags", {28'h0, cmp_flag}, 32'hF);
    repeat (5) @(negedge clk);
    rd(8'h08, d); chk("R3 idle hold after reset", d, 0);

    // R2 register map
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R2 cfg fields", d, 32'hF000_330F);
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R2 cfg cleared", d, 32'hF000_0000);
    for (int i = 0; i < 4; i++) begin
      wr(8'(32 + 4 * i), 32'hFFFF_ABC0 + 32'(i));
      rd(8'(32 + 4 * i), d); chk("R2 compare width", d, 32'h0000_ABC0 + 32'(i));
      cmpv[i] = 16'hABC0 + 16'(i);
    end
    rd(8'h04, d); chk("R2 unmapped", d, 0);
    rd(8'h30, d); chk("R2 unmapped high", d, 0);
    bus_addr = 8'h20; #1 chk("R2 no strobe", bus_rdata, 0); #1;

    // R3 R4 R5 all scales
    for (int s = 0; s < 16; s++) begin
      logic [31:0] v;
      v = (32'h2B3C_4D5E + 32'(s) * 32'h0011_1111) & 32'h7FFF_FFF0;
      wr(8'h00, 32'(s));
      wr(8'h08, v);
      rd(8'h08, d); chk("R4 load", d, v);
      rd(8'h10, d); chk("R5 scaled", d, {16'h0, 16'(v >> s)});
      chk_out("R6 static", 16'(v >> s));
      repeat (3) @(negedge clk);
      rd(8'h08, d); chk("R3 hold", d, v);
      wr(8'h00, 32'h1000 | 32'(s));
      rd(8'h08, c0); @(negedge clk); rd(8'h08, c1);
      chk("R3 step", c1, c0 + 1);
    end

    // R7 R11 wrap sweep scale 0 and scale 2
    set_cmp(0, 16'h0); set_cmp(1, 16'h1); set_cmp(2, 16'h8000); set_cmp(3, 16'hFFFF);
    for (int p = 0; p < 2; p++) begin
      int sh;
      logic [31:0] base, span;
      sh = p * 2;
      span = 32'h1_0000 << sh;
      base = span - 32'h10;
      wr(8'h00, 32'h1000 | 32'(sh));
      wr(8'h08, base);
      for (int k = 0; k < 40; k++) begin
        logic [31:0] e;
        e = (base + 32'(k)) % span;
        rd(8'h08, d); chk("R7 wrap count", d, e);
        chk_out("R6 running", 16'(e >> sh));
        chk("R11 max compare pin", {31'h0, pwm_n[3]}, {31'h0, 16'(e >> sh) != 16'hFFFF});
        @(negedge clk);
      end
    end

    // R8 zero-compare periods
    for (int p = 0; p < 2; p++) begin
      logic [15:0] c;
      int per;
      c = (p == 0) ? 16'd9 : 16'd3;
      per = (int'(c) << p) + 1;
      wr(8'h00, 32'h1200 | 32'(p));
      set_cmp(0, c);
      wr(8'h08, 32'h0);
      for (int k = 0; k < 30; k++) begin
        logic [31:0] e;
        e = 32'(k % per);
        rd(8'h08, d); chk("R8 zero-compare count", d, e);
        chk_out("R8 zero-compare", 16'(e >> p));
        @(negedge clk);
      end
    end

    // R9 run once
    wr(8'h00, 32'h0);
    set_cmp(0, 16'd5);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h2200);
    for (int k = 0; k < 12; k++) begin
      rd(8'h08, d); chk("R9 single period", d, (k <= 5) ? 32'(k) : 32'h0);
      @(negedge clk);
    end
    rd(8'h00, d); chk("R9 run-once bit cleared", {31'h0, d[13]}, 32'h0);

    // R10 sticky
    wr(8'h00, 32'h0);
    set_cmp(1, 16'h100);
    wr(8'h00, 32'h100);
    wr(8'h08, 32'h200);
    chk("R10 flags set", {28'h0, cmp_flag}, 32'h3);
    wr(8'h08, 32'h10);
    chk("R10 flags held", {28'h0, cmp_flag}, 32'h3);
    chk("R10 pins held", {28'h0, pwm_n}, 32'hC);
    rd(8'h00, d); chk("R10 flag readback", d, 32'h3000_0100);
    wr(8'h00, 32'h100);
    chk("R10 flags cleared", {28'h0, cmp_flag}, 32'h1);
    wr(8'h00, 32'h0);
    wr(8'h08, 32'h200);
    wr(8'h08, 32'h10);
    chk("R6 non-sticky follows count", {28'h0, cmp_flag}, 32'h1);

    done = 1;
    finish_run();
  end
endmodule